// File: doc/BRIEF.md
# Burst-Read Strobe Bus Slave

This block connects an asynchronous 8-bit processor bus to an on-chip register and buffer space. The bus uses separate address and data strobes, both active low. When the address strobe falls while chip select is active, the slave captures a 12-bit address. Each later fall of the data strobe with R/W high starts one read cycle. The slave issues a single-cycle request on a synchronous register-read port and then turns on its data drivers. One clock after the read data comes back, it presents that data and pulls its active-low transfer acknowledge.

The first read after an address phase fetches the captured address itself. Each later data-strobe cycle in the same burst moves the held address forward by one before fetching, and no new address phase is needed. All asynchronous bus controls are brought into the system clock through two-flop synchronizers, and their edges are detected after synchronization.

Top module: `strobe_bus_slave`

## Requirements
- R1: A falling address strobe (`bus_as_n` 1→0) while `bus_cs_n` is low loads `bus_addr` into the held address, and the next read of the burst fetches that address unchanged.
- R2: A data-strobe cycle with `bus_rw` low (write) issues no register read, leaves `bus_data_oe` low, keeps `bus_dtack_n` high, and does not advance the held address.
- R3: A falling data strobe with `bus_cs_n` low and `bus_rw` high raises `bus_data_oe` and pulses `reg_rd_en` high for exactly one clock, with `reg_rd_addr` giving the target location.
- R4: `reg_rd_data` is expected in the clock after `reg_rd_en`. `bus_dtack_n` goes low exactly two clocks after the `reg_rd_en` cycle, with `bus_data` equal to the returned byte, and `bus_data` stays unchanged while `bus_dtack_n` is low.
- R5: Each read after the first in a burst, started with no new address-strobe fall, fetches the held address plus one.
- R6: When the data strobe returns high, or `bus_cs_n` goes high, `bus_dtack_n` returns high and `bus_data_oe` returns low.
- R7: While `bus_cs_n` is high, both strobes are ignored: no address is loaded, no read is issued, and no acknowledge is given.
- R8: An address-strobe fall in the middle of a burst ends that burst, and the next read fetches the newly loaded address without an increment.
- R9: The held address wraps from 0xFFF to 0x000 when it is incremented.
- R10: If the address-strobe fall and the data-strobe fall are seen in the same synchronized clock, the read fetches the new `bus_addr` value with no increment, and the following read fetches that value plus one.
- R11: During and after reset, `bus_data_oe` is low, `bus_dtack_n` is high and `reg_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_as_n | input | 1 | Address strobe, active low, asynchronous |
| bus_ds_n | input | 1 | Data strobe, active low, asynchronous |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | 12 | Bus address, held stable while the address strobe is low |
| bus_data | inout | 8 | Bidirectional data bus, driven only during reads |
| bus_data_oe | output | 1 | High while the slave drives `bus_data` |
| bus_dtack_n | output | 1 | Data transfer acknowledge, active low |
| reg_rd_en | output | 1 | Single-cycle read request to the register space |
| reg_rd_addr | output | 12 | Read address to the register space |
| reg_rd_data | input | 8 | Read data, valid the clock after `reg_rd_en` |

## Verification
The address-strobe fall and the data-strobe fall can be detected in the same clock. A single reload would then compete with the burst increment. The bench provokes this by lowering both strobes in the same time step, so the synchronizers pass both edges through together. It then requires the issued read address to be the new bus address, and the next data-strobe cycle to fetch that address plus one. A scoreboard of expected addresses and bytes judges each read. Separate cases cover a reload in the middle of a burst and the wrap from 0xFFF.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_ACK   = 2'd3
    } sbs_state_e;

endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= async_i[i];
                stab_q <= meta_q;
            end
        end

        assign sync_o[i] = stab_q;
    end

endmodule

// File: rtl/sbs_burst_fsm.sv
module sbs_burst_fsm
    import sbs_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          as_lvl_n,
    input  logic          ds_lvl_n,
    input  logic          rw_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] rd_data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] dout,
    output logic          oe,
    output logic          ack
);

    typedef struct packed {
        sbs_state_e    st;
        logic [AW-1:0] addr;
        logic          first;
        logic          as_prev;
        logic          ds_prev;
        logic          rd_en;
        logic          oe;
        logic          ack;
        logic [DW-1:0] dout;
    } regs_t;

    regs_t r_d, r_q;
    logic  as_fall;
    logic  ds_fall;
    logic [AW-1:0] target;

    assign as_fall = r_q.as_prev & ~as_lvl_n & cs_act;
    assign ds_fall = r_q.ds_prev & ~ds_lvl_n & cs_act & rw_rd;

    always_comb begin
        r_d         = r_q;
        r_d.as_prev = as_lvl_n;
        r_d.ds_prev = ds_lvl_n;
        r_d.rd_en   = 1'b0;
        target      = r_q.addr;

        if (as_fall) begin
            r_d.addr  = bus_addr;
            r_d.first = 1'b1;
            r_d.st    = ST_IDLE;
            r_d.oe    = 1'b0;
            r_d.ack   = 1'b0;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (ds_fall) begin
                    if (as_fall) begin
                        target = bus_addr;
                    end else if (r_q.first) begin
                        target = r_q.addr;
                    end else begin
                        target = r_q.addr + 1'b1;
                    end
                    r_d.addr  = target;
                    r_d.first = 1'b0;
                    r_d.rd_en = 1'b1;
                    r_d.oe    = 1'b1;
                    r_d.st    = ST_ISSUE;
                end
            end
            default: begin
                if (!cs_act || ds_lvl_n || as_fall) begin
                    r_d.st  = ST_IDLE;
                    r_d.oe  = 1'b0;
                    r_d.ack = 1'b0;
                end else if (r_q.st == ST_ISSUE) begin
                    r_d.st = ST_WAIT;
                end else if (r_q.st == ST_WAIT) begin
                    r_d.dout = rd_data;
                    r_d.ack  = 1'b1;
                    r_d.st   = ST_ACK;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, first: 1'b1, as_prev: 1'b1,
                     ds_prev: 1'b1, rd_en: 1'b0, oe: 1'b0, ack: 1'b0,
                     dout: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_en   = r_q.rd_en;
    assign rd_addr = r_q.addr;
    assign dout    = r_q.dout;
    assign oe      = r_q.oe;
    assign ack     = r_q.ack;

    AST_RDEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en); // R3

    AST_RDEN_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ($past(cs_act) && $past(rw_rd))); // R7

    AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(rd_en, 2)); // R4

    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> $stable(dout)); // R4

    AST_ACK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> oe); // R3

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (ds_lvl_n || !cs_act)) |=> (!ack && !oe)); // R6

endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_as_n,
    input  logic          bus_ds_n,
    input  logic          bus_rw,
    input  logic [AW-1:0] bus_addr,
    inout  wire  [DW-1:0] bus_data,
    output logic          bus_data_oe,
    output logic          bus_dtack_n,
    output logic          reg_rd_en,
    output logic [AW-1:0] reg_rd_addr,
    input  logic [DW-1:0] reg_rd_data
);

    localparam int NSYNC = 4;

    logic [NSYNC-1:0] ctl_async;
    logic [NSYNC-1:0] ctl_sync;
    logic [DW-1:0]    dout;
    logic             oe;
    logic             ack;

    assign ctl_async = {bus_cs_n, bus_as_n, bus_ds_n, bus_rw};

    sbs_sync #(
        .W      (NSYNC),
        .RST_VAL({NSYNC{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ctl_async),
        .sync_o (ctl_sync)
    );

    sbs_burst_fsm #(
        .AW(AW),
        .DW(DW)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_act  (~ctl_sync[3]),
        .as_lvl_n(ctl_sync[2]),
        .ds_lvl_n(ctl_sync[1]),
        .rw_rd   (ctl_sync[0]),
        .bus_addr(bus_addr),
        .rd_data (reg_rd_data),
        .rd_en   (reg_rd_en),
        .rd_addr (reg_rd_addr),
        .dout    (dout),
        .oe      (oe),
        .ack     (ack)
    );

    assign bus_data    = oe ? dout : {DW{1'bz}};
    assign bus_data_oe = oe;
    assign bus_dtack_n = ~ack;

endmodule

// File: tb/strobe_bus_slave_test.sv
`timescale 1ns/1ps
module strobe_bus_slave_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1;
    logic        bus_as_n = 1'b1;
    logic        bus_ds_n = 1'b1;
    logic        bus_rw = 1'b1;
    logic [11:0] bus_addr = '0;
    wire  [7:0]  bus_data;
    logic        bus_data_oe;
    logic        bus_dtack_n;
    logic        reg_rd_en;
    logic [11:0] reg_rd_addr;
    logic [7:0]  reg_rd_data = '0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rd_cyc = 0;
    bit done = 0;
    bit ack_prev = 0;
    logic [7:0] held;

    logic [11:0] exp_addr_q[$];
    logic [7:0]  exp_data_q[$];
    string       exp_tag_q[$];

    always #2 clk = ~clk;

    strobe_bus_slave uut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_as_n(bus_as_n),
        .bus_ds_n(bus_ds_n), .bus_rw(bus_rw), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_data_oe(bus_data_oe),
        .bus_dtack_n(bus_dtack_n), .reg_rd_en(reg_rd_en),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    function automatic logic [7:0] mem_f(logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (reg_rd_en) reg_rd_data <= mem_f(reg_rd_addr);
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard on read request and on acknowledge
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_rd_en) begin
                if (exp_addr_q.size() == 0) begin
                    chk(0, "R7 unexpected read", int'(reg_rd_addr), 0);
                end else begin
                    chk(reg_rd_addr == exp_addr_q[0], exp_tag_q[0],
                        int'(reg_rd_addr), int'(exp_addr_q[0]));
                    void'(exp_addr_q.pop_front());
                end
                rd_cyc = cyc;
            end
            if (!bus_dtack_n && !ack_prev) begin
                chk(cyc - rd_cyc == 2, "R4 latency", cyc - rd_cyc, 2);
                chk(bus_data_oe == 1'b1, "R3 oe", int'(bus_data_oe), 1);
                if (exp_data_q.size() == 0) begin
                    chk(0, "R7 unexpected ack", int'(bus_data), 0);
                end else begin
                    chk(bus_data == exp_data_q[0], exp_tag_q[0],
                        int'(bus_data), int'(exp_data_q[0]));
                    void'(exp_data_q.pop_front());
                    void'(exp_tag_q.pop_front());
                end
                held = bus_data;
            end else if (!bus_dtack_n) begin
                chk(bus_data == held, "R4 hold", int'(bus_data), int'(held));
            end
            ack_prev = !bus_dtack_n;
        end
    end

    task automatic expect_read(logic [11:0] a, string tag);
        exp_addr_q.push_back(a);
        exp_data_q.push_back(mem_f(a));
        exp_tag_q.push_back(tag);
    endtask

    task automatic wait_ack(string tag);
        int n = 0;
        while (bus_dtack_n && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(!bus_dtack_n, tag, int'(bus_dtack_n), 0);
    endtask

    task automatic addr_phase(logic [11:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_as_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_as_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_cycle(logic [11:0] a, string tag);
        expect_read(a, tag);
        @(negedge clk);
        bus_ds_n = 1'b0;
        wait_ack(tag);
        repeat (2) @(negedge clk);
        bus_ds_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(bus_data_oe == 1'b0, "R6 release oe", int'(bus_data_oe), 0);
        chk(bus_dtack_n == 1'b1, "R6 release ack", int'(bus_dtack_n), 1);
    endtask

    task automatic quiet_strobe(string tag);
        @(negedge clk);
        bus_ds_n = 1'b0;
        repeat (10) @(negedge clk);
        chk(bus_data_oe == 1'b0, tag, int'(bus_data_oe), 0);
        chk(bus_dtack_n == 1'b1, tag, int'(bus_dtack_n), 1);
        bus_ds_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(bus_data_oe == 1'b0, "R11 oe", int'(bus_data_oe), 0);
        chk(bus_dtack_n == 1'b1, "R11 ack", int'(bus_dtack_n), 1);
        chk(reg_rd_en == 1'b0, "R11 rd_en", int'(reg_rd_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_data_oe == 1'b0, "R11 oe after", int'(bus_data_oe), 0);
        bus_cs_n = 1'b0;
        repeat (3) @(negedge clk);

        // R1 / R5: first read unchanged, then increments
        addr_phase(12'h040);
        read_cycle(12'h040, "R1");
        read_cycle(12'h041, "R5");
        read_cycle(12'h042, "R5");

        // R8: reload in the middle of a burst
        addr_phase(12'h7A0);
        read_cycle(12'h7A0, "R8");
        read_cycle(12'h7A1, "R5");

        // R2: write strobe ignored, address not advanced
        bus_rw = 1'b0;
        quiet_strobe("R2");
        bus_rw = 1'b1;
        repeat (3) @(negedge clk);
        read_cycle(12'h7A2, "R2");

        // R7: chip select inactive blocks both strobes
        bus_cs_n = 1'b1;
        repeat (3) @(negedge clk);
        addr_phase(12'h123);
        quiet_strobe("R7");
        bus_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        read_cycle(12'h7A3, "R7");

        // R9: wrap
        addr_phase(12'hFFE);
        read_cycle(12'hFFE, "R9");
        read_cycle(12'hFFF, "R9");
        read_cycle(12'h000, "R9");

        // R10: address and data strobes fall together
        expect_read(12'h5C3, "R10");
        @(negedge clk);
        bus_addr = 12'h5C3;
        bus_as_n = 1'b0;
        bus_ds_n = 1'b0;
        wait_ack("R10");
        repeat (2) @(negedge clk);
        bus_ds_n = 1'b1;
        bus_as_n = 1'b1;
        repeat (6) @(negedge clk);
        read_cycle(12'h5C4, "R10");

        // R6: chip select dropped during acknowledge
        addr_phase(12'h300);
        expect_read(12'h300, "R6");
        @(negedge clk);
        bus_ds_n = 1'b0;
        wait_ack("R6");
        bus_cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(bus_data_oe == 1'b0, "R6 cs oe", int'(bus_data_oe), 0);
        chk(bus_dtack_n == 1'b1, "R6 cs ack", int'(bus_dtack_n), 1);
        bus_ds_n = 1'b1;
        repeat (4) @(negedge clk);

        chk(exp_addr_q.size() == 0, "R3 pending reads", exp_addr_q.size(), 0);
        chk(exp_data_q.size() == 0, "R4 pending acks", exp_data_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

endmodule